// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Frame

This block is a small memory-mapped frame on a single-cycle register bus. It turns message-signalled interrupt writes into pulses on shared peripheral interrupt lines. Software, or a device writing its message, stores an interrupt ID into a doorbell register. If that ID falls inside the window the frame owns, exactly one line of a 64-wide interrupt vector pulses for one clock, ready for a distributor to latch.

The frame also describes itself. A read-only type word packs the first interrupt ID of the window together with the window size, so a driver can find the range without any other configuration. An identification word reads as zero. A doorbell ID outside the window fires nothing and instead sets a sticky error flag, which software clears through a separate clear register.

Top module: `msi_spi_frame`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `irq_pulse`, `err_flag` and `rsp_rdata` are all zero. Reset also clears an error flag that was set.
- R2: A read at offset 0x008 returns `{6'b0, FIRST_ID[9:0], 6'b0, NUM_IDS[9:0]}` on `rsp_rdata` in the cycle after the access. With the default parameters this value is 0x0040_0040.
- R3: A read at offset 0xFCC, at any other offset, or of the doorbell register returns zero in the cycle after the access.
- R4: A write at offset 0x040 whose ID lies in `[FIRST_ID, FIRST_ID+NUM_IDS)` drives bit `ID-FIRST_ID` of `irq_pulse` high in the cycle after the write. The bit is high for that one cycle only, and every other bit stays low.
- R5: The doorbell ID is `req_wdata[9:0]`. Write-data bits 31:10 have no effect on the range check or on the line chosen.
- R6: A doorbell ID below `FIRST_ID`, or at or above `FIRST_ID+NUM_IDS`, pulses no line. It sets `err_flag` in the next cycle, and the flag stays set until it is cleared.
- R7: A write at offset 0x044 with data bit 0 equal to 1 clears `err_flag` in the next cycle. The same write with bit 0 equal to 0 leaves the flag unchanged.
- R8: Writes at offsets 0x008 and 0xFCC are ignored. A later read of either register returns the same value as before, and such a write fires no line and sets no error.
- R9: Back-to-back doorbell writes produce back-to-back pulses. `irq_pulse` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the frame |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read, zero otherwise |
| err_flag | output | 1 | Sticky rejected-doorbell flag |
| irq_pulse | output | 64 | One-cycle interrupt line pulses, bit i for ID FIRST_ID+i |

## Verification
The properties assume that `req_valid` marks at most one access per cycle and that the offsets are byte addresses compared in full. They also assume that a write to the clear register and a doorbell write never occur in the same cycle. Both follow from the bus carrying a single request. The bench drives one request per cycle at the falling edge, using only aligned offsets. It reaches both window edges, both out-of-window neighbours and IDs with high garbage bits, so every path of the range check is taken without leaving those assumptions.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int ID_W   = 10;

    localparam logic [ADDR_W-1:0] OFS_TYPE  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_DOOR  = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_CLEAR = 12'h044;
    localparam logic [ADDR_W-1:0] OFS_IDENT = 12'hFCC;

    typedef struct packed {
        logic type_hit;
        logic door_hit;
        logic clear_hit;
        logic ident_hit;
    } frame_sel_t;

    function automatic logic [DATA_W-1:0] type_word(input int first_id, input int count);
        logic [ID_W-1:0] f;
        logic [ID_W-1:0] c;
        f = ID_W'(first_id);
        c = ID_W'(count);
        return {6'b0, f, 6'b0, c};
    endfunction

endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
    import msi_frame_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output frame_sel_t        sel
);
    always_comb begin
        sel           = '0;
        sel.type_hit  = (addr == OFS_TYPE);
        sel.door_hit  = (addr == OFS_DOOR);
        sel.clear_hit = (addr == OFS_CLEAR);
        sel.ident_hit = (addr == OFS_IDENT);
    end
endmodule

// File: rtl/msi_window_check.sv
module msi_window_check
    import msi_frame_pkg::*;
#(
    parameter int FIRST_ID = 64,
    parameter int NUM_IDS  = 64
) (
    input  logic [ID_W-1:0]    id,
    output logic               in_window,
    output logic [NUM_IDS-1:0] line_sel
);
    localparam logic [ID_W:0] LO_L = (ID_W+1)'(FIRST_ID);
    localparam logic [ID_W:0] HI_L = (ID_W+1)'(FIRST_ID + NUM_IDS);

    logic [ID_W:0] id_x;

    always_comb begin
        id_x      = {1'b0, id};
        in_window = (id_x >= LO_L) && (id_x < HI_L);
    end

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_line
        localparam logic [ID_W-1:0] MATCH_L = ID_W'(FIRST_ID + g);
        assign line_sel[g] = in_window && (id == MATCH_L);
    end
endmodule

// File: rtl/msi_spi_frame.sv
module msi_spi_frame
    import msi_frame_pkg::*;
#(
    parameter int FIRST_ID = 64,
    parameter int NUM_IDS  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               err_flag,
    output logic [NUM_IDS-1:0] irq_pulse
);
    localparam logic [DATA_W-1:0] TYPE_VAL = type_word(FIRST_ID, NUM_IDS);

    if (FIRST_ID < 32 || FIRST_ID + NUM_IDS > 1020) begin : g_bad_window
        $error("interrupt window outside shared peripheral range");
    end

    typedef struct packed {
        logic [NUM_IDS-1:0] irq;
        logic               err;
        logic [DATA_W-1:0]  rdata;
    } frame_state_t;

    frame_state_t       st_d, st_q;
    frame_sel_t         sel;
    logic               in_window;
    logic [NUM_IDS-1:0] line_sel;
    logic               unused_wdata_hi;

    msi_addr_decode dec_i (
        .addr (req_addr),
        .sel  (sel)
    );

    msi_window_check #(
        .FIRST_ID (FIRST_ID),
        .NUM_IDS  (NUM_IDS)
    ) win_i (
        .id        (req_wdata[ID_W-1:0]),
        .in_window (in_window),
        .line_sel  (line_sel)
    );

    always_comb begin
        logic wr;
        logic rd;
        wr              = req_valid && req_write;
        rd              = req_valid && !req_write;
        unused_wdata_hi = ^req_wdata[DATA_W-1:ID_W];

        st_d       = st_q;
        st_d.irq   = '0;
        st_d.rdata = '0;

        if (wr && sel.door_hit) begin
            if (in_window) begin
                st_d.irq = line_sel;
            end else begin
                st_d.err = 1'b1;
            end
        end

        if (wr && sel.clear_hit && req_wdata[0]) begin
            st_d.err = 1'b0;
        end

        if (rd && sel.type_hit) begin
            st_d.rdata = TYPE_VAL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_rdata = st_q.rdata;
    assign err_flag  = st_q.err;
    assign irq_pulse = st_q.irq;
endmodule

// File: rtl/msi_spi_frame_chk.sv
module msi_spi_frame_chk
    import msi_frame_pkg::*;
#(
    parameter int FIRST_ID = 64,
    parameter int NUM_IDS  = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [ID_W-1:0]    req_id,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic               err_flag,
    input logic [NUM_IDS-1:0] irq_pulse
);
    logic door_wr, clr_wr, type_rd, other_rd, id_ok;

    always_comb begin
        door_wr  = req_valid && req_write && (req_addr == OFS_DOOR);
        clr_wr   = req_valid && req_write && (req_addr == OFS_CLEAR) && req_id[0];
        type_rd  = req_valid && !req_write && (req_addr == OFS_TYPE);
        other_rd = req_valid && !req_write && (req_addr != OFS_TYPE);
        id_ok    = (int'(req_id) >= FIRST_ID) && (int'(req_id) < FIRST_ID + NUM_IDS);
    end

    // R9
    a_r9_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_pulse));

    // R4
    a_r4_pulse_needs_door: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse != '0) |-> $past(door_wr && id_ok));

    // R4
    a_r4_valid_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (door_wr && id_ok) |=> ($countones(irq_pulse) == 1));

    // R6
    a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (door_wr && !id_ok) |=> (err_flag && irq_pulse == '0));

    // R6
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr_wr) |=> err_flag);

    // R7
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !err_flag);

    // R2
    a_r2_type: assert property (@(posedge clk) disable iff (!rst_n)
        type_rd |=> (rsp_rdata == type_word(FIRST_ID, NUM_IDS)));

    // R3
    a_r3_zero: assert property (@(posedge clk) disable iff (!rst_n)
        other_rd |=> (rsp_rdata == '0));
endmodule

bind msi_spi_frame msi_spi_frame_chk #(
    .FIRST_ID (FIRST_ID),
    .NUM_IDS  (NUM_IDS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_id    (req_wdata[9:0]),
    .rsp_rdata (rsp_rdata),
    .err_flag  (err_flag),
    .irq_pulse (irq_pulse)
);

// File: tb/msi_spi_frame_tb_top.sv
`timescale 1ns/1ps
module msi_spi_frame_tb_top;
    localparam int FIRST = 64;
    localparam int NUM   = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [11:0]     req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic [31:0]     rsp_rdata;
    logic            err_flag;
    logic [NUM-1:0]  irq_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    msi_spi_frame #(.FIRST_ID(FIRST), .NUM_IDS(NUM)) dut_i (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
        .rsp_rdata, .err_flag, .irq_pulse
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] rdata;
        logic        fire;
        logic [5:0]  bitn;
        logic        err;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b0, 12'h008, 32'h0,        32'h0040_0040, 1'b0, 6'd0,  1'b0}, // R2
        '{4'd3, 1'b0, 12'hFCC, 32'h0,        32'h0,         1'b0, 6'd0,  1'b0}, // R3
        '{4'd3, 1'b0, 12'h100, 32'h0,        32'h0,         1'b0, 6'd0,  1'b0}, // R3
        '{4'd4, 1'b1, 12'h040, 32'd64,       32'h0,         1'b1, 6'd0,  1'b0}, // R4 low edge
        '{4'd4, 1'b1, 12'h040, 32'd127,      32'h0,         1'b1, 6'd63, 1'b0}, // R4 high edge
        '{4'd5, 1'b1, 12'h040, 32'hFFFF_F450, 32'h0,        1'b1, 6'd16, 1'b0}, // R5
        '{4'd6, 1'b1, 12'h040, 32'd63,       32'h0,         1'b0, 6'd0,  1'b1}, // R6 below
        '{4'd7, 1'b1, 12'h044, 32'h0,        32'h0,         1'b0, 6'd0,  1'b1}, // R7 no clear
        '{4'd6, 1'b0, 12'h008, 32'h0,        32'h0040_0040, 1'b0, 6'd0,  1'b1}, // R6 sticky
        '{4'd7, 1'b1, 12'h044, 32'h1,        32'h0,         1'b0, 6'd0,  1'b0}, // R7 clear
        '{4'd6, 1'b1, 12'h040, 32'd128,      32'h0,         1'b0, 6'd0,  1'b1}, // R6 above
        '{4'd7, 1'b1, 12'h044, 32'hFFFF_FFFF, 32'h0,        1'b0, 6'd0,  1'b0}, // R7
        '{4'd8, 1'b1, 12'h008, 32'hFFFF_FFFF, 32'h0,        1'b0, 6'd0,  1'b0}, // R8
        '{4'd8, 1'b0, 12'h008, 32'h0,        32'h0040_0040, 1'b0, 6'd0,  1'b0}, // R8
        '{4'd8, 1'b1, 12'hFCC, 32'h0000_1234, 32'h0,        1'b0, 6'd0,  1'b0}, // R8
        '{4'd8, 1'b0, 12'hFCC, 32'h0,        32'h0,         1'b0, 6'd0,  1'b0}, // R8
        '{4'd5, 1'b1, 12'h040, 32'h0000_0440, 32'h0,        1'b1, 6'd0,  1'b0}  // R5
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq in reset", 64'(irq_pulse), 64'h0);
        check("R1 err in reset", 64'(err_flag), 64'h0);
        check("R1 rdata in reset", 64'(rsp_rdata), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", 64'(irq_pulse), 64'h0);

        for (int i = 0; i < NV; i++) begin
            logic [63:0] exp_irq;
            exp_irq = VECS[i].fire ? (64'h1 << VECS[i].bitn) : 64'h0;
            access(VECS[i].wr, VECS[i].addr, VECS[i].wdata);
            check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), 64'(rsp_rdata), 64'(VECS[i].rdata));
            check($sformatf("R%0d vec%0d irq", VECS[i].req, i), 64'(irq_pulse), exp_irq);
            check($sformatf("R%0d vec%0d err", VECS[i].req, i), 64'(err_flag), 64'(VECS[i].err));
        end

        // R4: pulse lasts only one cycle
        access(1'b1, 12'h040, 32'd100);
        check("R4 pulse bit36", 64'(irq_pulse), 64'h1 << 36);
        @(negedge clk);
        check("R4 pulse gone", 64'(irq_pulse), 64'h0);

        // R9: back-to-back doorbells
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h040; req_wdata = 32'd70;
        @(negedge clk);
        req_wdata = 32'd71;
        check("R9 first of pair", 64'(irq_pulse), 64'h1 << 6);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R9 second of pair", 64'(irq_pulse), 64'h1 << 7);
        @(negedge clk);
        check("R9 quiet after pair", 64'(irq_pulse), 64'h0);

        // R1: reset clears a set error
        access(1'b1, 12'h040, 32'd5);
        check("R6 error set", 64'(err_flag), 64'h1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears error", 64'(err_flag), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule